// File: doc/BRIEF.md
# I2C Slave Byte Buffer with Auto-Incrementing Pointer

This block is a 7-bit addressed I2C target that gives a bus master access to a small on-chip byte buffer. It oversamples the SCL and SDA lines with the system clock and finds START, repeated START and STOP conditions. It shifts in the address byte and compares it with a software-writable own-address register. On a match it acknowledges, then serves a write or a read transaction.

In a write transaction the first data byte does not reach the buffer. It becomes the base pointer. The bytes that follow are stored at the base pointer and then at consecutive addresses. A read transaction never changes the base pointer. It always starts at the stored base pointer and walks forward one byte per acknowledged transfer, so a master can read back a region without setting the pointer again. Two status outputs, busy and direction, show whether a transaction addressed to this slave is in progress and which way it goes.

Top module: `i2c_buffer_slave`

## Requirements
- R1: After reset `ownAddr` reads 0. A cycle with `ownAddrWr` high loads `ownAddrWdata` into the own-address register, and `ownAddr` shows the new value from the next cycle on.
- R2: The line inputs pass through a two-flop synchronizer. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes are received MSB first. In the address byte, bits 7..1 are the address and bit 0 selects the direction (1 = master read).
- R3: When the received address equals `ownAddr`, the slave pulls SDA low (`sdaOe` = 1) during the ninth clock. On a mismatch it gives no ACK and ignores the bus until the next START.
- R4: `busy` goes to 1 on an address match, stays 1 across a repeated START, and returns to 0 on STOP.
- R5: While `busy` is 1, `dirRead` is 1 for a master read and 0 for a master write.
- R6: In a write transaction the slave ACKs the first data byte and loads it into the base pointer. The byte is not stored in the buffer.
- R7: Each later write byte in the same transaction is ACKed and stored at the base pointer, then at base+1, base+2 and so on.
- R8: A read transaction returns bytes MSB first, starting at the base pointer and advancing one address after each byte. The base pointer is left unchanged, so every new read transaction starts again at the base pointer.
- R9: The pointers wrap from 31 back to 0 when they advance past the end of the 32-byte buffer.
- R10: When the master NACKs a read byte, the slave releases SDA and does not drive it again until the next START.
- R11: Only the low 5 bits of the pointer byte are used. The upper 3 bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| ownAddrWr | input | 1 | Write strobe for the own-address register |
| ownAddrWdata | input | 7 | New own address |
| ownAddr | output | 7 | Current own address |
| busy | output | 1 | A matched transaction is in progress |
| dirRead | output | 1 | 1 for a master read, 0 for a master write |

## Verification
The bench builds the block with its default parameters: a 32-entry buffer, which gives 5-bit pointers, and a two-stage synchronizer. With 32 entries, a write starting at pointer 30 runs across the wrap in four bytes. The line model holds each SCL phase for ten system clocks. That covers the three-cycle synchronizer lag, so the slave's ACK and data bits settle well before the master samples them. Repeated START, an address mismatch, a NACK followed by extra clocking, and a read that reuses the stored pointer are each driven as their own transaction.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;     // shift sampled SDA into receive register
    logic setBase;     // pointer byte complete: load base and current pointer
    logic storeByte;   // data byte complete: write buffer, advance pointer
    logic curFromBase; // read transaction: current pointer restarts at base
    logic txLoad;      // fetch next byte to send, advance pointer
    logic txShift;     // move to next transmit bit
  } dpStrobe_t;
endpackage

// File: rtl/ibs_datapath.sv
module ibs_datapath
  import ibs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  input  logic              ownAddrWr,
  input  logic [ADDR_W-1:0] ownAddrWdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] ownAddr
);
  logic [BYTE_W-1:0] rxReg;
  logic [BYTE_W-1:0] txReg;
  logic [PTR_W-1:0]  basePtr;
  logic [PTR_W-1:0]  curPtr;
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= RESET_ADDR;
    else if (ownAddrWr) addrReg <= ownAddrWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '1;
      basePtr <= '0;
      curPtr  <= '0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[BYTE_W-2:0], sdaBit};
      if (strb.setBase) begin
        basePtr <= rxReg[PTR_W-1:0];
        curPtr  <= rxReg[PTR_W-1:0];
      end
      if (strb.storeByte) curPtr <= nextPtr(curPtr);
      if (strb.curFromBase) curPtr <= basePtr;
      if (strb.txLoad) begin
        txReg  <= mem[curPtr];
        curPtr <= nextPtr(curPtr);
      end else if (strb.txShift) begin
        txReg <= {txReg[BYTE_W-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeByte) mem[curPtr] <= rxReg;
  end

  assign rxByte  = rxReg;
  assign txBit   = txReg[BYTE_W-1];
  assign ownAddr = addrReg;

  // at most one pointer-moving strobe per cycle
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setBase, strb.storeByte, strb.curFromBase, strb.txLoad}));  // R7
  // a read fetch never happens in the same cycle as a base update
  AST_READ_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> $stable(basePtr));  // R8
endmodule

// File: rtl/ibs_ctrl.sv
module ibs_ctrl
  import ibs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic [ADDR_W-1:0] ownAddr,
  output dpStrobe_t         strb,
  output logic              sdaBit,
  output logic              sdaOe,
  output logic              busy,
  output logic              dirRead
);
  logic [SYNC_STAGES:0] sclPipe;
  logic [SYNC_STAGES:0] sdaPipe;
  logic sclS, sclPrev, sdaS, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet, busEvent;
  logic addrMatch, byteDone;
  busState_t state;
  logic [3:0] bitCnt;
  logic firstByte;
  logic mAck;
  logic busyR, dirR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sclPrev  = sclPipe[SYNC_STAGES];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sdaPrev  = sdaPipe[SYNC_STAGES];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign busEvent = startDet || stopDet;
  assign addrMatch = (rxByte[BYTE_W-1:1] == ownAddr);
  assign byteDone  = sclFall && (bitCnt == 4'd8);
  assign sdaBit    = sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      firstByte <= 1'b0;
      mAck      <= 1'b0;
      busyR     <= 1'b0;
      dirR      <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      busyR <= 1'b0;
      dirR  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            if (addrMatch) begin
              state     <= ST_ADDR_ACK;
              busyR     <= 1'b1;
              dirR      <= rxByte[0];
              firstByte <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= dirR ? ST_RD : ST_WR;
        end
        ST_WR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            state     <= ST_WR_ACK;
            firstByte <= 1'b0;
          end
        end
        ST_WR_ACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= ST_WR;
        end
        ST_RD: if (sclFall) begin
          if (bitCnt == 4'd7) begin
            bitCnt <= '0;
            state  <= ST_RD_ACK;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (sclRise) mAck <= !sdaS;
          if (sclFall) state <= mAck ? ST_RD : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    if (!busEvent) begin
      strb.rxShift     = sclRise && (state == ST_ADDR || state == ST_WR);
      strb.setBase     = (state == ST_WR) && byteDone && firstByte;
      strb.storeByte   = (state == ST_WR) && byteDone && !firstByte;
      strb.curFromBase = (state == ST_ADDR) && byteDone && addrMatch && rxByte[0];
      strb.txLoad      = sclFall && ((state == ST_ADDR_ACK && dirR) ||
                                     (state == ST_RD_ACK && mAck));
      strb.txShift     = (state == ST_RD) && sclFall && (bitCnt != 4'd7);
    end
  end

  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_WR_ACK: sdaOe = 1'b1;
      ST_RD:                  sdaOe = !txBit;
      default:                sdaOe = 1'b0;
    endcase
  end

  assign busy    = busyR;
  assign dirRead = dirR;

  AST_OE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclS);  // R2
  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> busy);  // R3
  AST_BUSY_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteDone && addrMatch && !busEvent) |=> busy);  // R4
  AST_BUSY_CLEAR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !busy);  // R4
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_ACK && sclFall && !mAck && !busEvent) |=> !sdaOe);  // R10
endmodule

// File: rtl/i2c_buffer_slave.sv
module i2c_buffer_slave
  import ibs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] RESET_ADDR = 7'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       ownAddrWr,
  input  logic [6:0] ownAddrWdata,
  output logic [6:0] ownAddr,
  output logic       busy,
  output logic       dirRead
);
  dpStrobe_t strb;
  logic [BYTE_W-1:0] rxByte;
  logic txBit;
  logic sdaBit;

  ibs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .ownAddr(ownAddr),
    .strb(strb), .sdaBit(sdaBit), .sdaOe(sdaOe),
    .busy(busy), .dirRead(dirRead)
  );

  ibs_datapath #(.DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit),
    .ownAddrWr(ownAddrWr), .ownAddrWdata(ownAddrWdata),
    .rxByte(rxByte), .txBit(txBit), .ownAddr(ownAddr)
  );
endmodule

// File: tb/sim_i2c_buffer_slave.sv
`timescale 1ns/1ps
module sim_i2c_buffer_slave;
  localparam int Q = 10;  // system clocks per SCL phase
  localparam logic [6:0] MY_ADDR = 7'h52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic ownAddrWr = 1'b0;
  logic [6:0] ownAddrWdata = '0;
  logic [6:0] ownAddr;
  logic busy, dirRead;
  logic sdaBus;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] obsQ[$];

  assign sdaBus = mSda & ~sdaOe;

  always #4 clk = ~clk;

  i2c_buffer_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .ownAddrWr(ownAddrWr), .ownAddrWdata(ownAddrWdata), .ownAddr(ownAddr),
    .busy(busy), .dirRead(dirRead)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic s);
    mSda = b;
    waitClk(Q);
    scl = 1'b1;
    waitClk(Q / 2);
    s = sdaBus;
    waitClk(Q / 2);
    scl = 1'b0;
    waitClk(Q / 2);
  endtask

  task automatic startCond();
    mSda = 1'b1;
    waitClk(Q);
    scl = 1'b1;
    waitClk(Q);
    mSda = 1'b0;
    waitClk(Q);
    scl = 1'b0;
    waitClk(Q / 2);
  endtask

  task automatic stopCond();
    mSda = 1'b0;
    waitClk(Q);
    scl = 1'b1;
    waitClk(Q);
    mSda = 1'b1;
    waitClk(Q);
  endtask

  task automatic writeByte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(d[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  // driver: pushes the expected byte, observed byte goes to the monitor
  task automatic readByte(input logic [7:0] exp, input string tag, input logic nack);
    logic [7:0] d;
    logic s;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    obsQ.push_back(d);
    clockBit(nack, s);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      wait (obsQ.size() > 0);
      begin
        logic [7:0] o, e;
        string t;
        o = obsQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, o, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic ack;
    waitClk(5);
    check("R1 reset ownAddr", ownAddr, 0);
    check("R4 reset busy", busy, 0);
    check("R3 reset sdaOe", sdaOe, 0);
    rstN = 1'b1;
    waitClk(3);

    ownAddrWdata = MY_ADDR;
    ownAddrWr = 1'b1;
    waitClk(1);
    ownAddrWr = 1'b0;
    waitClk(1);
    check("R1 ownAddr readback", ownAddr, MY_ADDR);

    // write: pointer byte 0xE4 -> base 4 (R11), data 11 22 33
    startCond();
    writeByte({MY_ADDR, 1'b0}, ack);
    check("R3 address ACK", ack, 1);
    check("R4 busy after match", busy, 1);
    check("R5 dir write", dirRead, 0);
    writeByte(8'hE4, ack);
    check("R6 pointer byte ACK", ack, 1);
    writeByte(8'h11, ack);
    check("R7 data ACK", ack, 1);
    writeByte(8'h22, ack);
    writeByte(8'h33, ack);
    check("R7 data ACK last", ack, 1);
    stopCond();
    check("R4 busy cleared on STOP", busy, 0);

    // read from base, then NACK and keep clocking
    startCond();
    writeByte({MY_ADDR, 1'b1}, ack);
    check("R3 read address ACK", ack, 1);
    check("R5 dir read", dirRead, 1);
    readByte(8'h11, "R6 R11 R8 byte0", 1'b0);
    readByte(8'h22, "R8 byte1", 1'b0);
    readByte(8'h33, "R8 byte2", 1'b1);
    readByte(8'hFF, "R10 released after NACK", 1'b1);
    stopCond();

    // second read restarts at base
    startCond();
    writeByte({MY_ADDR, 1'b1}, ack);
    readByte(8'h11, "R8 restart at base", 1'b1);
    stopCond();

    // mismatched address
    startCond();
    writeByte({MY_ADDR ^ 7'h01, 1'b0}, ack);
    check("R3 mismatch no ACK", ack, 0);
    check("R4 busy stays low on mismatch", busy, 0);
    writeByte(8'h00, ack);
    check("R3 ignored after mismatch", ack, 0);
    stopCond();
    startCond();
    writeByte({MY_ADDR, 1'b1}, ack);
    readByte(8'h11, "R3 buffer untouched by mismatch", 1'b1);
    stopCond();

    // wrap across end of buffer
    startCond();
    writeByte({MY_ADDR, 1'b0}, ack);
    writeByte(8'd30, ack);
    writeByte(8'hA0, ack);
    writeByte(8'hA1, ack);
    writeByte(8'hA2, ack);
    writeByte(8'hA3, ack);
    check("R9 write across wrap ACK", ack, 1);
    stopCond();
    startCond();
    writeByte({MY_ADDR, 1'b1}, ack);
    readByte(8'hA0, "R9 addr30", 1'b0);
    readByte(8'hA1, "R9 addr31", 1'b0);
    readByte(8'hA2, "R9 addr0", 1'b0);
    readByte(8'hA3, "R9 addr1", 1'b1);
    stopCond();

    // set pointer then repeated START into a read
    startCond();
    writeByte({MY_ADDR, 1'b0}, ack);
    writeByte(8'd0, ack);
    startCond();
    check("R4 busy holds over repeated START", busy, 1);
    writeByte({MY_ADDR, 1'b1}, ack);
    check("R3 ACK after repeated START", ack, 1);
    check("R5 dir read after repeated START", dirRead, 1);
    readByte(8'hA2, "R8 repeated START byte0", 1'b0);
    readByte(8'hA3, "R8 repeated START byte1", 1'b1);
    stopCond();
    check("R4 busy cleared after read", busy, 0);

    waitClk(4);
    wait (obsQ.size() == 0);
    waitClk(2);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule